// File: doc/BRIEF.md
# Paged Register SPI Access Master

This block lets on-chip logic read and write byte-addressed registers on an external device whose register space is split into pages. The host presents a page number, a register address, a transfer length of 1, 2 or 4 bytes, a direction and, for writes, the data. The block then runs the serial exchange on a four-wire SPI bus and returns a one-cycle completion pulse, an error flag and, for reads, the assembled data.

The block remembers which page the device currently has selected. When a request targets a different page, or no page has been selected since reset, it first runs a separate page-select exchange and then the access itself. A read does not take the first bytes it receives as data. It keeps clocking filler bytes until the device returns a byte with bit 0 set, which marks the device as ready. The bytes after that marker are the data. If the marker never arrives, a retry limit ends the read with an error.

The SCK phase lengths, the MOSI setup margin and the select setup time are parameters counted in system clock cycles.

Top module: `spi_paged_master`

## Requirements
- R1: While no request is in progress, the select line is high and SCK and MOSI are low. The select line goes low for the duration of each exchange and returns high when the exchange ends.
- R2: Each byte is sent most significant bit first. MOSI changes only while SCK is low. SCK stays high for exactly EDGE_CYC cycles. Within a byte, SCK stays low for at least EDGE_CYC+SETUP_CYC cycles before each rising edge.
- R3: A write exchange shifts out the byte 0x61, then the register address, then `len` data bytes with the least significant byte first.
- R4: When the requested page differs from the remembered page, a separate page-select exchange (0x61, 0xFF, page number) runs before the access. When the page matches, no page-select exchange runs.
- R5: After reset no page is remembered, so the first legal request always runs a page-select exchange.
- R6: A read exchange shifts out 0x10, then the register address, and then keeps MOSI low. Received bytes are discarded until the first one with bit 0 set, and that byte is not data. The next `len` bytes form the result, least significant first, and the unused upper result bytes read as zero.
- R7: If MAX_POLL bytes in a row arrive without bit 0 set, the read stops. The select line is released and the completion pulse is raised together with the error flag. The page-select exchange that came before still counts as done.
- R8: A request whose length is not 1, 2 or 4 causes no bus activity. The cycle after the request, the completion pulse and the error flag are both high. The remembered page does not change.
- R9: `busy_o` is high from the cycle after a request is accepted until the completion pulse. Requests presented while busy are ignored and cause no extra bus activity and no extra completion pulse.
- R10: At least SS_CYC cycles pass between the select line going low and the first SCK rising edge. Between two exchanges, the select line stays high for at least SS_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| page_i | input | 8 | Target page number |
| addr_i | input | 8 | Register address within the page |
| len_i | input | 3 | Transfer length in bytes (1, 2 or 4 legal) |
| wdata_i | input | 32 | Write data, least significant byte sent first |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error, valid with done_o (bad length or read timeout) |
| rdata_o | output | 32 | Read result, valid with done_o |
| spi_ss_n_o | output | 1 | Device select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to device |
| spi_miso_i | input | 1 | Serial data from device |

## Verification
The embedded properties check the line levels on every cycle. While the block is idle, the select line is high and SCK and MOSI are low. SCK is never high while the device is deselected. MOSI holds steady while SCK is high. The error flag appears only with the completion pulse, and a request made while busy leaves the latched page alone. Other behaviour only shows up when the bench's device model decodes whole exchanges. That covers the byte contents and their order, skipping the page-select when the page is unchanged, where the ready marker falls in a read and the retry limit, and the exact high and low phase lengths. The bench drives random mixes of pages, lengths and ready delays alongside directed cases for an illegal length, a poke while busy and a marker that never arrives.

// File: rtl/spm_pkg.sv
package spm_pkg;

    localparam logic [7:0] CMD_WRITE    = 8'h61;
    localparam logic [7:0] CMD_FASTREAD = 8'h10;
    localparam logic [7:0] PAGE_SEL_REG = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_LEAD,
        ST_SHIFT,
        ST_WAIT,
        ST_TAIL
    } xfer_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } bit_phase_e;

endpackage

// File: rtl/spm_byte_shifter.sv
module spm_byte_shifter
    import spm_pkg::*;
#(
    parameter int EDGE_CYC  = 500,
    parameter int SETUP_CYC = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_o
);

    localparam int LOW_CYC = EDGE_CYC + SETUP_CYC;
    localparam int CNT_W   = $clog2(LOW_CYC + 1);

    typedef struct packed {
        bit_phase_e       ph;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       bitn;
        logic [7:0]       tx;
        logic [7:0]       rx;
        logic             sck;
        logic             mosi;
        logic             done;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        unique case (sh_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    sh_d.ph   = PH_LOW;
                    sh_d.cnt  = '0;
                    sh_d.bitn = '0;
                    sh_d.tx   = tx_i;
                    sh_d.mosi = tx_i[7];
                    sh_d.sck  = 1'b0;
                end
            end
            PH_LOW: begin
                if (sh_q.cnt == CNT_W'(LOW_CYC - 1)) begin
                    sh_d.rx  = {sh_q.rx[6:0], miso_i};
                    sh_d.sck = 1'b1;
                    sh_d.ph  = PH_HIGH;
                    sh_d.cnt = '0;
                end else begin
                    sh_d.cnt = sh_q.cnt + 1'b1;
                end
            end
            PH_HIGH: begin
                if (sh_q.cnt == CNT_W'(EDGE_CYC - 1)) begin
                    sh_d.sck = 1'b0;
                    sh_d.cnt = '0;
                    if (sh_q.bitn == 3'd7) begin
                        sh_d.ph   = PH_IDLE;
                        sh_d.done = 1'b1;
                        sh_d.mosi = 1'b0;
                    end else begin
                        sh_d.bitn = sh_q.bitn + 1'b1;
                        sh_d.tx   = {sh_q.tx[6:0], 1'b0};
                        sh_d.mosi = sh_q.tx[6];
                        sh_d.ph   = PH_LOW;
                    end
                end else begin
                    sh_d.cnt = sh_q.cnt + 1'b1;
                end
            end
            default: sh_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '{ph: PH_IDLE, cnt: '0, bitn: '0, tx: '0, rx: '0,
                      sck: 1'b0, mosi: 1'b0, done: 1'b0};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sck_o  = sh_q.sck;
    assign mosi_o = sh_q.mosi;
    assign done_o = sh_q.done;
    assign rx_o   = sh_q.rx;

    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.sck |-> $stable(sh_q.mosi)); // R2
    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (sh_q.ph == PH_IDLE)); // R2

endmodule

// File: rtl/spm_page_cache.sv
module spm_page_cache #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [PAGE_W-1:0] upd_page_i,
    input  logic [PAGE_W-1:0] cmp_page_i,
    output logic              hit_o
);

    typedef struct packed {
        logic              valid;
        logic [PAGE_W-1:0] page;
    } cache_t;

    cache_t pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (upd_i) begin
            pc_d.valid = 1'b1;
            pc_d.page  = upd_page_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '{valid: 1'b0, page: '0};
        end else begin
            pc_q <= pc_d;
        end
    end

    assign hit_o = pc_q.valid && (pc_q.page == cmp_page_i);

    AST_CACHE_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> hit_o || (cmp_page_i != $past(upd_page_i))); // R5

endmodule

// File: rtl/spi_paged_master.sv
module spi_paged_master
    import spm_pkg::*;
#(
    parameter int PAGE_W     = 8,
    parameter int ADDR_W     = 8,
    parameter int DATA_BYTES = 4,
    parameter int EDGE_CYC   = 500,
    parameter int SETUP_CYC  = 250,
    parameter int SS_CYC     = 250,
    parameter int MAX_POLL   = 100
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_i,
    input  logic                      wr_i,
    input  logic [PAGE_W-1:0]         page_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [$clog2(DATA_BYTES+1)-1:0] len_i,
    input  logic [8*DATA_BYTES-1:0]   wdata_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      err_o,
    output logic [8*DATA_BYTES-1:0]   rdata_o,
    output logic                      spi_ss_n_o,
    output logic                      spi_sck_o,
    output logic                      spi_mosi_o,
    input  logic                      spi_miso_i
);

    localparam int DATA_W = 8 * DATA_BYTES;
    localparam int LEN_W  = $clog2(DATA_BYTES + 1);
    localparam int IDX_W  = $clog2(DATA_BYTES + 3);
    localparam int POLL_W = $clog2(MAX_POLL + 1);
    localparam int TMR_W  = $clog2(SS_CYC + 1);

    typedef struct packed {
        xfer_state_e       state;
        logic              is_page;
        logic              wr;
        logic [PAGE_W-1:0] page;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] wdata;
        logic [IDX_W-1:0]  idx;
        logic              ack;
        logic [POLL_W-1:0] polls;
        logic [LEN_W-1:0]  dcnt;
        logic [DATA_W-1:0] rdata;
        logic [TMR_W-1:0]  timer;
        logic              ss_n;
        logic              fail;
        logic              done;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic       sh_start;
    logic [7:0] sh_tx;
    logic       sh_done;
    logic [7:0] sh_rx;
    logic       cache_hit;
    logic       cache_upd;
    logic       end_txn;
    logic       len_ok;
    logic [7:0] tx_sel;

    spm_byte_shifter #(
        .EDGE_CYC  (EDGE_CYC),
        .SETUP_CYC (SETUP_CYC)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sh_start),
        .tx_i    (sh_tx),
        .miso_i  (spi_miso_i),
        .sck_o   (spi_sck_o),
        .mosi_o  (spi_mosi_o),
        .done_o  (sh_done),
        .rx_o    (sh_rx)
    );

    spm_page_cache #(
        .PAGE_W (PAGE_W)
    ) u_page_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_i      (cache_upd),
        .upd_page_i (ctl_q.page),
        .cmp_page_i (ctl_q.page),
        .hit_o      (cache_hit)
    );

    // legal lengths: nonzero powers of two that fit the data path
    always_comb begin
        len_ok = (len_i != '0) && ((len_i & (len_i - 1'b1)) == '0)
                 && (int'(len_i) <= DATA_BYTES);
    end

    always_comb begin
        if (ctl_q.idx == '0) begin
            tx_sel = (ctl_q.is_page || ctl_q.wr) ? CMD_WRITE : CMD_FASTREAD;
        end else if (ctl_q.idx == IDX_W'(1)) begin
            tx_sel = ctl_q.is_page ? PAGE_SEL_REG : 8'(ctl_q.addr);
        end else if (ctl_q.is_page) begin
            tx_sel = 8'(ctl_q.page);
        end else if (ctl_q.wr) begin
            tx_sel = ctl_q.wdata[7:0];
        end else begin
            tx_sel = 8'h00;
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        sh_start   = 1'b0;
        sh_tx      = 8'h00;
        cache_upd  = 1'b0;
        end_txn    = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    if (!len_ok) begin
                        ctl_d.done = 1'b1;
                        ctl_d.err  = 1'b1;
                    end else begin
                        ctl_d.state = ST_PLAN;
                        ctl_d.wr    = wr_i;
                        ctl_d.page  = page_i;
                        ctl_d.addr  = addr_i;
                        ctl_d.len   = len_i;
                        ctl_d.wdata = wdata_i;
                    end
                end
            end
            ST_PLAN: begin
                ctl_d.is_page = !cache_hit;
                ctl_d.ss_n    = 1'b0;
                ctl_d.timer   = '0;
                ctl_d.idx     = '0;
                ctl_d.ack     = 1'b0;
                ctl_d.polls   = '0;
                ctl_d.dcnt    = '0;
                ctl_d.rdata   = '0;
                ctl_d.fail    = 1'b0;
                ctl_d.state   = ST_LEAD;
            end
            ST_LEAD: begin
                if (ctl_q.timer == TMR_W'(SS_CYC - 1)) begin
                    ctl_d.timer = '0;
                    ctl_d.state = ST_SHIFT;
                end else begin
                    ctl_d.timer = ctl_q.timer + 1'b1;
                end
            end
            ST_SHIFT: begin
                sh_start    = 1'b1;
                sh_tx       = tx_sel;
                ctl_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (sh_done) begin
                    ctl_d.state = ST_SHIFT;
                    if (ctl_q.is_page) begin
                        if (ctl_q.idx == IDX_W'(2)) begin
                            end_txn = 1'b1;
                        end else begin
                            ctl_d.idx = ctl_q.idx + 1'b1;
                        end
                    end else if (ctl_q.wr) begin
                        if (ctl_q.idx >= IDX_W'(2)) begin
                            ctl_d.wdata = ctl_q.wdata >> 8;
                        end
                        if (ctl_q.idx == IDX_W'(ctl_q.len) + IDX_W'(1)) begin
                            end_txn = 1'b1;
                        end else begin
                            ctl_d.idx = ctl_q.idx + 1'b1;
                        end
                    end else if (ctl_q.idx < IDX_W'(2)) begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end else if (!ctl_q.ack) begin
                        if (sh_rx[0]) begin
                            ctl_d.ack = 1'b1;
                        end else if (ctl_q.polls == POLL_W'(MAX_POLL - 1)) begin
                            ctl_d.fail = 1'b1;
                            end_txn    = 1'b1;
                        end else begin
                            ctl_d.polls = ctl_q.polls + 1'b1;
                        end
                    end else begin
                        ctl_d.rdata = ctl_q.rdata | (DATA_W'(sh_rx) << (8 * ctl_q.dcnt));
                        if (ctl_q.dcnt == LEN_W'(ctl_q.len - 1'b1)) begin
                            end_txn = 1'b1;
                        end else begin
                            ctl_d.dcnt = ctl_q.dcnt + 1'b1;
                        end
                    end
                    if (end_txn) begin
                        ctl_d.ss_n  = 1'b1;
                        ctl_d.timer = '0;
                        ctl_d.state = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (ctl_q.timer == TMR_W'(SS_CYC - 1)) begin
                    ctl_d.timer = '0;
                    if (ctl_q.is_page) begin
                        cache_upd     = 1'b1;
                        ctl_d.is_page = 1'b0;
                        ctl_d.idx     = '0;
                        ctl_d.ss_n    = 1'b0;
                        ctl_d.state   = ST_LEAD;
                    end else begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.done  = 1'b1;
                        ctl_d.err   = ctl_q.fail;
                    end
                end else begin
                    ctl_d.timer = ctl_q.timer + 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, is_page: 1'b0, wr: 1'b0, page: '0, addr: '0,
                       len: '0, wdata: '0, idx: '0, ack: 1'b0, polls: '0, dcnt: '0,
                       rdata: '0, timer: '0, ss_n: 1'b1, fail: 1'b0, done: 1'b0,
                       err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o     = (ctl_q.state != ST_IDLE);
    assign done_o     = ctl_q.done;
    assign err_o      = ctl_q.err;
    assign rdata_o    = ctl_q.rdata;
    assign spi_ss_n_o = ctl_q.ss_n;

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (spi_ss_n_o && !spi_sck_o && !spi_mosi_o)); // R1
    AST_SCK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck_o |-> !spi_ss_n_o); // R1
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o); // R7
    AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R9
    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_i) |=> $stable(ctl_q.page)); // R9
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.polls < POLL_W'(MAX_POLL)); // R7

endmodule

// File: tb/spi_paged_master_tb.sv
module spi_paged_master_tb;

    localparam int EDGE  = 3;
    localparam int SETUP = 2;
    localparam int SSC   = 4;
    localparam int POLLS = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  page = '0;
    logic [7:0]  addr = '0;
    logic [2:0]  len = '0;
    logic [31:0] wdata = '0;
    logic        busy, done, err;
    logic [31:0] rdata;
    logic        ss_n, sck, mosi;
    logic        miso = 1'b0;

    always #2 clk = ~clk;

    spi_paged_master #(
        .EDGE_CYC  (EDGE),
        .SETUP_CYC (SETUP),
        .SS_CYC    (SSC),
        .MAX_POLL  (POLLS)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .wr_i       (wr),
        .page_i     (page),
        .addr_i     (addr),
        .len_i      (len),
        .wdata_i    (wdata),
        .busy_o     (busy),
        .done_o     (done),
        .err_o      (err),
        .rdata_o    (rdata),
        .spi_ss_n_o (ss_n),
        .spi_sck_o  (sck),
        .spi_mosi_o (mosi),
        .spi_miso_i (miso)
    );

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    // device model state, owned by the monitor process
    int         fr_n = 0;
    logic [7:0] fr_bytes [0:3][0:127];
    int         fr_len [0:3];
    int         bitc = 0;
    logic [7:0] cur = '0;
    int         done_total = 0;
    int         viol_edge = 0;
    int         viol_mosi = 0;
    int         viol_ss = 0;
    int         low_run = 100, high_run = 0;
    int         ss_low_run = 0, ss_high_run = 100;
    bit         first_rise = 0;
    logic       p_sck = 0, p_mosi = 0, p_ss = 1;

    // response behaviour, owned by the stimulus process
    int          resp_wait = 0;
    logic [31:0] resp_val = '0;
    bit          resp_noack = 0;

    function automatic logic [7:0] resp_byte(int k);
        if (resp_noack) return 8'h5E;
        if (k < resp_wait) return (k % 2) ? 8'hFE : 8'h00;
        if (k == resp_wait) return 8'h81;
        if (k - resp_wait - 1 < 4) return 8'(resp_val >> (8 * (k - resp_wait - 1)));
        return 8'h00;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            p_sck = 0; p_ss = 1; p_mosi = 0; miso = 0;
        end else begin
            int ci;
            if (done) done_total++;
            if (!ss_n && p_ss) begin
                if (ss_high_run < SSC) viol_ss++;
                fr_n++;
                fr_len[(fr_n - 1) % 4] = 0;
                bitc = 0;
                ss_low_run = 1;
                first_rise = 1;
            end else if (!ss_n) begin
                ss_low_run++;
            end
            if (ss_n && !p_ss) ss_high_run = 1;
            else if (ss_n) ss_high_run++;
            ci = (fr_n - 1) % 4;
            if (sck && !p_sck) begin
                if (low_run < EDGE + SETUP) viol_edge++;
                if (first_rise) begin
                    if (ss_low_run < SSC) viol_ss++;
                    first_rise = 0;
                end
                high_run = 1;
                if (!ss_n && fr_n > 0) begin
                    cur = {cur[6:0], mosi};
                    bitc++;
                    if (bitc == 8) begin
                        if (fr_len[ci] < 128) fr_bytes[ci][fr_len[ci]] = cur;
                        fr_len[ci]++;
                        bitc = 0;
                    end
                end
            end else if (sck) begin
                high_run++;
                if (mosi != p_mosi) viol_mosi++;
            end else if (p_sck) begin
                if (high_run != EDGE) viol_edge++;
                low_run = 1;
            end else begin
                low_run++;
            end
            if (!ss_n && fr_n > 0 && fr_len[ci] >= 2 && fr_bytes[ci][0] == 8'h10)
                miso = resp_byte(fr_len[ci] - 2)[7 - bitc];
            else
                miso = 1'b0;
            p_sck = sck; p_ss = ss_n; p_mosi = mosi;
        end
    end

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // bench model of the remembered page
    bit         m_valid = 0;
    logic [7:0] m_page = '0;

    task automatic check_frame(int idx, logic [7:0] exp[], string rq);
        int bad = -1;
        chk(fr_len[idx] == exp.size(), rq, "frame length", fr_len[idx], exp.size());
        for (int j = 0; j < exp.size() && j < fr_len[idx] && j < 128; j++)
            if (bad < 0 && fr_bytes[idx][j] !== exp[j]) bad = j;
        chk(bad < 0, rq, "frame byte", bad < 0 ? 0 : fr_bytes[idx][bad],
            bad < 0 ? 0 : exp[bad]);
    endtask

    task automatic do_op(bit w, logic [7:0] pg, logic [7:0] ad, logic [2:0] ln,
                         logic [31:0] wd, int wn, logic [31:0] rv, bit noack,
                         bit poke, string rq);
        int base, dbase, nfr, k;
        bit legal, pgsel, got_err;
        logic [31:0] got_rd, msk;
        logic [7:0] e[];
        legal = (ln == 1 || ln == 2 || ln == 4);
        pgsel = legal && (!m_valid || m_page != pg);
        resp_wait = wn; resp_val = rv; resp_noack = noack;
        base = fr_n; dbase = done_total;
        @(negedge clk);
        req = 1; wr = w; page = pg; addr = ad; len = ln; wdata = wd;
        @(negedge clk);
        req = 0;
        if (!legal) begin
            chk(done === 1'b1 && err === 1'b1, "R8", "done/err on bad length",
                {done, err}, 2'b11);
            chk(busy === 1'b0, "R8", "busy after bad length", busy, 0);
        end else begin
            if (poke) begin
                repeat (6) @(negedge clk);
                chk(busy === 1'b1, "R9", "busy during op", busy, 1);
                req = 1; wr = ~w; page = pg ^ 8'h55; len = 3'd1;
                @(negedge clk);
                req = 0;
            end
            k = 0;
            while (done !== 1'b1 && k < 20000) begin
                @(negedge clk);
                k++;
            end
        end
        got_err = err; got_rd = rdata;
        chk(ss_n === 1'b1 && sck === 1'b0 && mosi === 1'b0, "R1", "lines at done",
            {ss_n, sck, mosi}, 3'b100);
        repeat (3) @(negedge clk);
        chk(done_total - dbase == 1, "R9", "completion pulses", done_total - dbase, 1);
        nfr = fr_n - base;
        chk(nfr == (legal ? (pgsel ? 2 : 1) : 0), pgsel ? "R5" : "R4",
            "exchange count", nfr, legal ? (pgsel ? 2 : 1) : 0);
        if (legal && nfr == (pgsel ? 2 : 1)) begin
            if (pgsel) begin
                e = new[3];
                e[0] = 8'h61; e[1] = 8'hFF; e[2] = pg;
                check_frame(base % 4, e, "R4");
            end
            if (w) begin
                e = new[2 + ln];
                e[0] = 8'h61; e[1] = ad;
                for (int j = 0; j < ln; j++) e[2 + j] = 8'(wd >> (8 * j));
                check_frame((fr_n - 1) % 4, e, "R3");
                chk(got_err == 0, "R3", "write error flag", got_err, 0);
            end else begin
                e = new[noack ? 2 + POLLS : 3 + wn + ln];
                foreach (e[j]) e[j] = 8'h00;
                e[0] = 8'h10; e[1] = ad;
                check_frame((fr_n - 1) % 4, e, noack ? "R7" : "R6");
                if (noack) begin
                    chk(got_err == 1, "R7", "timeout error flag", got_err, 1);
                end else begin
                    msk = (ln == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * ln)) - 1);
                    chk(got_err == 0, "R6", "read error flag", got_err, 0);
                    chk(got_rd == (rv & msk), "R6", "read data", got_rd, rv & msk);
                end
            end
        end
        if (legal) begin
            m_valid = 1; m_page = pg;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ss_n === 1 && sck === 0 && mosi === 0 && busy === 0 && done === 0,
            "R1", "reset levels", {ss_n, sck, mosi, busy, done}, 5'b10000);
        // R5: first access selects a page; R3 write frame
        do_op(1, 8'h03, 8'h2C, 3'd2, 32'hDEAD_BEEF, 0, 0, 0, 0, "R5");
        // R4: same page, no page select
        do_op(1, 8'h03, 8'h40, 3'd4, 32'h1234_5678, 0, 0, 0, 0, "R4");
        // R6: read, immediate ready marker
        do_op(0, 8'h03, 8'h11, 3'd1, 0, 0, 32'hA5C3_7E19, 0, 0, "R6");
        // R6: read after several discarded bytes
        do_op(0, 8'h03, 8'h12, 3'd4, 0, 5, 32'hCAFE_F00D, 0, 0, "R6");
        // R4: page change on a read
        do_op(0, 8'h07, 8'h30, 3'd2, 0, 3, 32'h0000_BEE5, 0, 0, "R4");
        // R8: illegal lengths leave the cache alone
        do_op(1, 8'h09, 8'h01, 3'd3, 32'hFFFF_FFFF, 0, 0, 0, 0, "R8");
        do_op(0, 8'h09, 8'h01, 3'd0, 0, 0, 0, 0, 0, "R8");
        do_op(0, 8'h07, 8'h31, 3'd1, 0, 1, 32'h0000_0042, 0, 0, "R8");
        // R9: request poke while busy
        do_op(1, 8'h07, 8'h50, 3'd4, 32'h0BAD_CAFE, 0, 0, 0, 1, "R9");
        // R7: no ready marker, then page stays remembered
        do_op(0, 8'h02, 8'h60, 3'd2, 0, 0, 0, 1, 0, "R7");
        do_op(0, 8'h02, 8'h61, 3'd2, 0, 2, 32'h0000_7711, 0, 0, "R7");
        for (int i = 0; i < 30; i++) begin
            logic [2:0] ln;
            case ($urandom % 3)
                0: ln = 3'd1;
                1: ln = 3'd2;
                default: ln = 3'd4;
            endcase
            do_op(1'($urandom), 8'(1 + $urandom % 3), 8'($urandom), ln, $urandom,
                  int'($urandom % 7), $urandom, 0, 0, "R6");
        end
        chk(viol_edge == 0, "R2", "SCK phase violations", viol_edge, 0);
        chk(viol_mosi == 0, "R2", "MOSI change while SCK high", viol_mosi, 0);
        chk(viol_ss == 0, "R10", "select setup violations", viol_ss, 0);
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule